// File: doc/BRIEF.md
# Self-Synchronizing PRBS Bit Error Checker

This block checks a serial bit stream against a pseudo-random binary sequence without being aligned to the source. The only thing it needs to know is the generator polynomial, chosen with a select input from a 9-, 15- or 23-stage sequence. Each bit arrives on `bit_i` and is accepted only when `valid_i` is high.

After reset or a restart, the checker loads received bits straight into its shift register until it holds as many bits as the selected polynomial has stages. It then switches the register to its own feedback, so the register produces the bit the stream should carry next. From that point it compares every accepted bit with the predicted bit and counts both accepted bits and mismatches in saturating counters. Because the lock starts from whatever bits arrive first, checking can begin anywhere in the stream, and any delay between the source and the checker is tolerated.

A fill that captures all zeros would leave the generator stuck, so the checker discards it and starts the fill again. A restart pulse clears the lock and both counters and samples the polynomial select again.

Top module: `prbs_err_checker`

## Requirements
- R1: `poly_sel_i` picks the recurrence b[n] = b[n-a] XOR b[n-b]. Code 0 gives (a,b) = (9,5), code 1 gives (15,14), and codes 2 and 3 both give (23,18).
- R2: After reset or a restart, `locked_o` is low. It goes high in the cycle after the N-th accepted fill bit, where N is 9, 15 or 23 for the selected polynomial. Cycles with `valid_i` low add nothing to the fill.
- R3: If all N fill bits are zero, `locked_o` stays low and the fill starts over, needing N new accepted bits.
- R4: While locked, every accepted bit adds one to `bit_cnt_o`. It also adds one to `err_cnt_o` when it differs from the predicted bit. Both counts are visible in the cycle after the bit is accepted.
- R5: While locked, the register advances on its own predicted bit and not on the received bit, so a single flipped bit in the stream is counted as exactly one error.
- R6: While `locked_o` is low, both counters read zero and do not change.
- R7: `restart_i` clears `locked_o` and both counters in the next cycle. It overrides `valid_i` in the same cycle, so the bit offered in that cycle is dropped.
- R8: `poly_sel_i` is sampled only in the first cycle after reset is released and in restart cycles. A change at any other time has no effect until the next restart.
- R9: Both counters are CNT_W bits wide (32 by default) and hold at all ones instead of wrapping.
- R10: While in reset, `locked_o` is low and both counters are zero.
- R11: The checker locks and runs with no errors no matter which point of the sequence the stream starts at.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Received data bit |
| valid_i | input | 1 | `bit_i` is accepted in this cycle |
| restart_i | input | 1 | Clears lock and counters, restarts the fill |
| poly_sel_i | input | 2 | Polynomial select (see R1) |
| bit_cnt_o | output | CNT_W | Accepted bits counted since lock |
| err_cnt_o | output | CNT_W | Mismatched bits counted since lock |
| locked_o | output | 1 | Register is in feedback mode |

## Verification
The bench starts the stream at an arbitrary point of each sequence and mixes idle cycles into the fill. A design that counted idle cycles, or used the wrong lengths or taps, would lock early or report errors on a clean stream. A single injected flip must add exactly one error; a checker that fed received bits back into the register would count three. An all-zero fill, a select change without a restart, a restart that arrives together with a valid bit, and saturation of both counters are each driven on purpose. A wrong design would then lock onto a dead state, switch polynomial early, count the dropped bit, or wrap to zero.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
  localparam int unsigned SR_W = 23;
  localparam int unsigned LEN_W = $clog2(SR_W + 1);

  typedef enum logic [1:0] {
    POLY_P9   = 2'd0,
    POLY_P15  = 2'd1,
    POLY_P23  = 2'd2,
    POLY_P23B = 2'd3
  } poly_e;

  function automatic logic [LEN_W-1:0] poly_len(poly_e p);
    case (p)
      POLY_P9:  return LEN_W'(9);
      POLY_P15: return LEN_W'(15);
      default:  return LEN_W'(23);
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] poly_tap(poly_e p);
    case (p)
      POLY_P9:  return LEN_W'(5);
      POLY_P15: return LEN_W'(14);
      default:  return LEN_W'(18);
    endcase
  endfunction

  function automatic logic [SR_W-1:0] len_mask(logic [LEN_W-1:0] n);
    logic [SR_W-1:0] m;
    for (int i = 0; i < SR_W; i++) m[i] = (LEN_W'(i) < n);
    return m;
  endfunction
endpackage

// File: rtl/prbs_chk_lfsr.sv
module prbs_chk_lfsr
  import prbs_chk_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  shift_i,
  input  logic  fill_i,
  input  logic  din_i,
  input  poly_e poly_i,
  output logic  pred_o,
  output logic  fill_zero_o
);
  logic [SR_W-1:0]  sr_q, sr_in;
  logic [LEN_W-1:0] len, tap;

  assign len    = poly_len(poly_i);
  assign tap    = poly_tap(poly_i);
  // sr_q[k-1] holds the bit seen k steps ago
  assign pred_o = sr_q[len - 1'b1] ^ sr_q[tap - 1'b1];
  assign sr_in  = {sr_q[SR_W-2:0], fill_i ? din_i : pred_o};
  assign fill_zero_o = ((sr_in & len_mask(len)) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (clr_i)   sr_q <= '0;
    else if (shift_i) sr_q <= sr_in;
  end
endmodule

// File: rtl/prbs_chk_sync.sv
module prbs_chk_sync
  import prbs_chk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             valid_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             fill_zero_i,
  output logic             locked_o
);
  logic [LEN_W-1:0] fill_q;
  logic             locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q   <= '0;
      locked_q <= 1'b0;
    end else if (restart_i) begin
      fill_q   <= '0;
      locked_q <= 1'b0;
    end else if (valid_i && !locked_q) begin
      if (fill_q == len_i - 1'b1) begin
        fill_q <= '0;
        // a dead all-zero state cannot generate; refill instead
        locked_q <= !fill_zero_i;
      end else begin
        fill_q <= fill_q + 1'b1;
      end
    end
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/prbs_chk_satcnt.sv
module prbs_chk_satcnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (inc_i && (cnt_q != '1))  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/prbs_err_checker.sv
module prbs_err_checker
  import prbs_chk_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             valid_i,
  input  logic             restart_i,
  input  logic [1:0]       poly_sel_i,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             locked_o
);
  localparam int unsigned N_CNT = 2;

  poly_e            poly_q, poly_use;
  logic             fresh_q;
  logic             locked, pred, fill_zero, shift;
  logic [N_CNT-1:0] inc;
  logic [CNT_W-1:0] cnt [N_CNT];

  // select is captured on the first cycle out of reset and on restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poly_q  <= POLY_P9;
      fresh_q <= 1'b1;
    end else begin
      if (restart_i || fresh_q) poly_q <= poly_e'(poly_sel_i);
      fresh_q <= 1'b0;
    end
  end

  assign poly_use = (restart_i || fresh_q) ? poly_e'(poly_sel_i) : poly_q;
  assign shift    = valid_i && !restart_i;

  prbs_chk_lfsr u_lfsr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (restart_i),
    .shift_i     (shift),
    .fill_i      (!locked),
    .din_i       (bit_i),
    .poly_i      (poly_use),
    .pred_o      (pred),
    .fill_zero_o (fill_zero)
  );

  prbs_chk_sync u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart_i),
    .valid_i     (valid_i),
    .len_i       (poly_len(poly_use)),
    .fill_zero_i (fill_zero),
    .locked_o    (locked)
  );

  assign inc[0] = locked && shift;
  assign inc[1] = inc[0] && (pred ^ bit_i);

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    prbs_chk_satcnt #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (restart_i),
      .inc_i  (inc[g]),
      .cnt_o  (cnt[g])
    );
  end

  assign bit_cnt_o = cnt[0];
  assign err_cnt_o = cnt[1];
  assign locked_o  = locked;
endmodule

// File: rtl/prbs_err_checker_sva.sv
module prbs_err_checker_sva #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_i,
  input logic             valid_i,
  input logic             restart_i,
  input logic [1:0]       poly_sel_i,
  input logic [CNT_W-1:0] bit_cnt_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic             locked_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r2_lock_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(valid_i) && !$past(restart_i));

  a_r2_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o && !restart_i |=> locked_o);

  a_r4_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o && valid_i && !restart_i && (bit_cnt_o != CMAX)
    |=> bit_cnt_o == $past(bit_cnt_o) + 1'b1);

  a_r4_err_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> (err_cnt_o == $past(err_cnt_o)) || (err_cnt_o == $past(err_cnt_o) + 1'b1));

  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> (bit_cnt_o == '0) && (err_cnt_o == '0));

  a_r7_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !locked_o && (bit_cnt_o == '0) && (err_cnt_o == '0));

  a_r9_bit_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt_o == CMAX) && !restart_i |=> bit_cnt_o == CMAX);

  a_r9_err_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == CMAX) && !restart_i |=> err_cnt_o == CMAX);
endmodule

bind prbs_err_checker prbs_err_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_i      (bit_i),
  .valid_i    (valid_i),
  .restart_i  (restart_i),
  .poly_sel_i (poly_sel_i),
  .bit_cnt_o  (bit_cnt_o),
  .err_cnt_o  (err_cnt_o),
  .locked_o   (locked_o)
);

// File: tb/prbs_err_checker_test.sv
module prbs_err_checker_test;
  localparam int CLK_P = 10;
  localparam int CW    = 10;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_in = 1'b0, valid = 1'b0, restart = 1'b0;
  logic [1:0]    sel = 2'd0;
  logic [CW-1:0] bit_cnt, err_cnt;
  logic          locked;

  int total = 0;
  int bad = 0;

  // scoreboard queues, one entry per driven cycle
  int    q_bc[$];
  int    q_ec[$];
  int    q_lk[$];
  string q_tag[$];

  // bench model state
  int   m_bc, m_ec, m_fill, m_sel;
  bit   m_lk, m_allz, m_fresh;
  // stream generator state
  logic [22:0] g_hist;
  int   g_sel;

  always #(CLK_P/2) clk = ~clk;

  prbs_err_checker #(.CNT_W(CW)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bit_i      (bit_in),
    .valid_i    (valid),
    .restart_i  (restart),
    .poly_sel_i (sel),
    .bit_cnt_o  (bit_cnt),
    .err_cnt_o  (err_cnt),
    .locked_o   (locked)
  );

  function automatic int len_of(int s);
    return (s == 0) ? 9 : (s == 1) ? 15 : 23;
  endfunction

  function automatic int tap_of(int s);
    return (s == 0) ? 5 : (s == 1) ? 14 : 18;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: compares one item per clock, after the edge has settled
  always begin
    @(posedge clk);
    #1;
    if (q_tag.size() > 0) begin
      string t;
      int eb, ee, el;
      t  = q_tag.pop_front();
      eb = q_bc.pop_front();
      ee = q_ec.pop_front();
      el = q_lk.pop_front();
      check(t, "locked", int'(locked), el);
      check(t, "bit_cnt", int'(bit_cnt), eb);
      check(t, "err_cnt", int'(err_cnt), ee);
    end
  end

  function automatic logic gen_next();
    logic nb;
    nb = g_hist[len_of(g_sel)-1] ^ g_hist[tap_of(g_sel)-1];
    g_hist = {g_hist[21:0], nb};
    return nb;
  endfunction

  task automatic reseed(int s, logic [22:0] seed, int skip);
    g_sel  = s;
    g_hist = seed;
    for (int i = 0; i < skip; i++) void'(gen_next());
  endtask

  // driver: drives one cycle and pushes the expected post-edge state
  task automatic cyc(bit v, bit b, bit rs, int s, bit inj, string tag);
    @(negedge clk);
    valid   = v;
    bit_in  = b ^ inj;
    restart = rs;
    sel     = 2'(s);
    if (rs || m_fresh) m_sel = s;
    m_fresh = 0;
    if (rs) begin
      m_lk = 0; m_fill = 0; m_allz = 1; m_bc = 0; m_ec = 0;
    end else if (v) begin
      if (!m_lk) begin
        m_fill++;
        if (b ^ inj) m_allz = 0;
        if (m_fill == len_of(m_sel)) begin
          if (!m_allz) m_lk = 1;
          m_fill = 0;
          m_allz = 1;
        end
      end else begin
        if (m_bc != CMAX) m_bc++;
        if (inj && m_ec != CMAX) m_ec++;
      end
    end
    q_tag.push_back(tag);
    q_bc.push_back(m_bc);
    q_ec.push_back(m_ec);
    q_lk.push_back(int'(m_lk));
  endtask

  task automatic send(int n, int s, bit inj, string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, gen_next(), 1'b0, s, inj, tag);
  endtask

  task automatic do_restart(int s, bit v, string tag);
    cyc(v, 1'b1, 1'b1, s, 1'b0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_bc = 0; m_ec = 0; m_fill = 0; m_sel = 0;
    m_lk = 0; m_allz = 1; m_fresh = 1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "locked", int'(locked), 0);
    check("R10", "bit_cnt", int'(bit_cnt), 0);
    check("R10", "err_cnt", int'(err_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R11: PRBS9 from an arbitrary phase, idle cycles inside the fill
    reseed(0, 23'h5A5A5, 37);
    for (int i = 0; i < 9; i++) begin
      cyc(1'b1, gen_next(), 1'b0, 0, 1'b0, "R2");
      if (i % 3 == 1) cyc(1'b0, 1'b1, 1'b0, 0, 1'b0, "R2");
    end
    send(40, 0, 1'b0, "R11");
    // R5: one flipped bit counts once
    send(1, 0, 1'b1, "R5");
    send(30, 0, 1'b0, "R5");
    repeat (3) cyc(1'b0, 1'b0, 1'b0, 0, 1'b0, "R6");

    // R7: restart together with valid; PRBS15 with sparse errors
    do_restart(1, 1'b1, "R7");
    reseed(1, 23'h01234, 101);
    send(15, 1, 1'b0, "R1");
    for (int k = 0; k < 3; k++) begin
      send(20, 1, 1'b0, "R4");
      send(1, 1, 1'b1, "R4");
    end

    // R8: select changes without restart have no effect
    do_restart(2, 1'b0, "R7");
    reseed(2, 23'h3F00D, 5);
    send(23, 2, 1'b0, "R1");
    send(60, 0, 1'b0, "R8");

    // R1: code 3 maps to the 23-stage sequence
    do_restart(3, 1'b0, "R7");
    reseed(2, 23'h1BEEF, 777);
    send(23, 3, 1'b0, "R1");
    send(40, 3, 1'b0, "R1");

    // R3: all-zero fill is discarded
    do_restart(0, 1'b0, "R7");
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b0, 1'b0, 0, 1'b0, "R3");
    reseed(0, 23'h000C3, 11);
    send(9, 0, 1'b0, "R3");
    send(20, 0, 1'b0, "R3");

    // R9: saturation of both counters
    do_restart(0, 1'b0, "R7");
    reseed(0, 23'h00155, 3);
    send(9, 0, 1'b0, "R9");
    send(600, 0, 1'b0, "R9");
    send(1100, 0, 1'b1, "R9");
    do_restart(0, 1'b0, "R7");

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule